// File: doc/BRIEF.md
# SDRAM Power-Up Initialization and Refresh Sequencer

This block brings an SDR SDRAM out of power-up and then keeps it refreshed. After reset it holds the command pins at NOP for the required stabilisation time. It then closes all banks and performs two auto-refresh cycles. Next it programs the mode register with a word built from parameters: burst length, burst ordering, CAS latency and write-burst behaviour. Each step waits a parameterised number of cycles before the next one. The flag `init_done` rises once the final mode-register delay has elapsed.

After initialization, a pacer counts clock cycles and adds one owed refresh at every refresh interval. By default the interval is 64 ms spread over 4096 rows, about 15.6 µs. The interval in cycles comes from a clock-frequency parameter. The owed count saturates at a parameterised ceiling. The sequencer offers each owed refresh to the command arbiter as a request/grant handshake. The handshake follows valid/ready rules:
- `ref_req` stays high until `ref_gnt` is sampled high on the same clock edge.
- The arbiter applies back-pressure by holding `ref_gnt` low.
- A grant while the request is low has no effect.

On a grant, the AUTO REFRESH command appears on the command pins in the next cycle. The request then stays low for the refresh recovery time.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the command pins {cs_n,ras_n,cas_n,we_n} read 4'b0111 (NOP), and `init_done` and `ref_req` are low.
- R2: For the first CLK_MHZ*POWERUP_US cycles after reset release (cycles 0 through PWR-1), the command is NOP (4'b0111) and the address is zero.
- R3: In cycle PWR the command is PRECHARGE (4'b0010) with address bit 10 set (all banks). NOP with a zero address follows for T_RP-1 cycles.
- R4: AUTO REFRESH (4'b0001) is issued in cycles PWR+T_RP and PWR+T_RP+T_RFC, each followed by NOPs up to T_RFC cycles later.
- R5: In cycle PWR+T_RP+2*T_RFC the command is LOAD MODE REGISTER (4'b0000) with bank address 0. The address carries these fields:
  - bits 2:0: burst-length code (1→000, 2→001, 4→010, 8→011, full page→111);
  - bit 3: burst type (1 = interleaved);
  - bits 6:4: CAS latency;
  - bits 8:7: 00;
  - bit 9: 1 = single-location writes;
  - bits 12:10: 0.
- R6: `init_done` rises exactly T_MRD cycles after the LOAD MODE REGISTER cycle and stays high until reset. Only NOPs occur between the two.
- R7: After `init_done`, one refresh is owed every CLK_MHZ*REFRESH_NS/1000 cycles. `ref_req` is high whenever a refresh is owed and no refresh recovery is in progress. Once high, it stays high until granted.
- R8: When `ref_req` and `ref_gnt` are both high at a clock edge, the next cycle carries AUTO REFRESH (4'b0001). `ref_req` then stays low for T_RFC cycles.
- R9: `ref_gnt` has no effect while `ref_req` is low, including during initialization. The command stays NOP apart from the sequence steps above.
- R10: The owed-refresh count saturates at MAX_OWED. After a long stall, exactly MAX_OWED refreshes are granted back to back before the request drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Arbiter grant for the pending refresh |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus (all-bank flag, mode word) |
| sd_ba | output | BA_W | Bank address, always zero from this block |
| init_done | output | 1 | Power-up sequence complete |
| ref_req | output | 1 | Refresh request toward the arbiter |

## Verification
The bench builds the block with CLK_MHZ=50 and POWERUP_US=2, so the NOP phase lasts 100 cycles and initialization finishes at cycle 119. With T_RP=3, T_RFC=7 and T_MRD=2, every gap and its boundary cycle can be checked against exact cycle numbers. REFRESH_NS=600 gives a 30-cycle refresh interval. MAX_OWED=3 lets a 300-cycle grant stall reach saturation and drain within a short run. The mode word uses burst length 4, sequential order, CAS latency 3 and single-location writes, which places nonzero values in three separate fields.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [3:0] {
    ST_POWER, ST_PRE, ST_TRP, ST_IREF_A, ST_TRFC_A, ST_IREF_B, ST_TRFC_B,
    ST_LMR, ST_TMRD, ST_IDLE, ST_AREF, ST_ATRFC
  } seq_st_e;

  function automatic logic [2:0] bl_field(input int bl);
    case (bl)
      1:       return 3'b000;
      2:       return 3'b001;
      4:       return 3'b010;
      8:       return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

  function automatic logic [12:0] mode_word(input int bl, input int interleave,
                                            input int cl, input int single_wr);
    logic [12:0] w;
    w       = '0;
    w[2:0]  = bl_field(bl);
    w[3]    = (interleave != 0);
    w[6:4]  = cl[2:0];
    w[8:7]  = 2'b00;
    w[9]    = (single_wr != 0);
    return w;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= W'(RST_VAL);
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sdram_refresh_pacer.sv
module sdram_refresh_pacer #(
  parameter int INTERVAL = 1560,
  parameter int MAX_OWED = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic take,
  output logic pending
);
  localparam int CW = $clog2(INTERVAL + 1);
  localparam int OW = $clog2(MAX_OWED + 1);

  logic [CW-1:0] cnt;
  logic [OW-1:0] owed;
  logic          tick;

  assign tick = en && (cnt == CW'(INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt <= '0;
    else if (en) cnt <= tick ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owed <= '0;
    else begin
      case ({tick, take})
        2'b10:   if (owed != OW'(MAX_OWED)) owed <= owed + 1'b1;
        2'b01:   if (owed != '0)            owed <= owed - 1'b1;
        default: owed <= owed;
      endcase
    end
  end

  assign pending = (owed != '0);
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int T_RP  = 3,
  parameter int T_RFC = 7,
  parameter int T_MRD = 2,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         expired,
  input  logic         ref_pending,
  input  logic         ref_gnt,
  output logic         t_load,
  output logic [W-1:0] t_val,
  output sd_cmd_e      cmd,
  output logic         pre_all,
  output logic         lmr_sel,
  output logic         done,
  output logic         req,
  output logic         take
);
  seq_st_e st, st_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_POWER;
    else        st <= st_nx;
  end

  assign req  = (st == ST_IDLE) && ref_pending;
  assign take = req && ref_gnt;

  always_comb begin
    st_nx  = st;
    t_load = 1'b0;
    t_val  = '0;
    case (st)
      ST_POWER:  if (expired) st_nx = ST_PRE;
      ST_PRE:    begin st_nx = ST_TRP;    t_load = 1'b1; t_val = W'(T_RP - 2);  end
      ST_TRP:    if (expired) st_nx = ST_IREF_A;
      ST_IREF_A: begin st_nx = ST_TRFC_A; t_load = 1'b1; t_val = W'(T_RFC - 2); end
      ST_TRFC_A: if (expired) st_nx = ST_IREF_B;
      ST_IREF_B: begin st_nx = ST_TRFC_B; t_load = 1'b1; t_val = W'(T_RFC - 2); end
      ST_TRFC_B: if (expired) st_nx = ST_LMR;
      ST_LMR:    begin st_nx = ST_TMRD;   t_load = 1'b1; t_val = W'(T_MRD - 2); end
      ST_TMRD:   if (expired) st_nx = ST_IDLE;
      ST_IDLE:   if (take) st_nx = ST_AREF;
      ST_AREF:   begin st_nx = ST_ATRFC;  t_load = 1'b1; t_val = W'(T_RFC - 2); end
      ST_ATRFC:  if (expired) st_nx = ST_IDLE;
      default:   st_nx = ST_POWER;
    endcase
  end

  always_comb begin
    case (st)
      ST_PRE:                        cmd = CMD_PRE;
      ST_IREF_A, ST_IREF_B, ST_AREF: cmd = CMD_REF;
      ST_LMR:                        cmd = CMD_LMR;
      default:                       cmd = CMD_NOP;
    endcase
  end

  assign pre_all = (st == ST_PRE);
  assign lmr_sel = (st == ST_LMR);
  assign done    = (st == ST_IDLE) || (st == ST_AREF) || (st == ST_ATRFC);
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ          = 100,
  parameter int POWERUP_US       = 100,
  parameter int REFRESH_NS       = 15625,
  parameter int T_RP             = 3,
  parameter int T_RFC            = 7,
  parameter int T_MRD            = 2,
  parameter int BURST_LEN        = 4,
  parameter int BURST_INTERLEAVE = 0,
  parameter int CAS_LAT          = 3,
  parameter int WRITE_SINGLE     = 0,
  parameter int MAX_OWED         = 8,
  parameter int ADDR_W           = 13,
  parameter int BA_W             = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_gnt,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba,
  output logic              init_done,
  output logic              ref_req
);
  localparam int          PWR_CYC  = CLK_MHZ * POWERUP_US;
  localparam int          REFI_CYC = (CLK_MHZ * REFRESH_NS) / 1000;
  localparam int          TW       = $clog2(max3(PWR_CYC, T_RFC, max3(T_RP, T_MRD, 2)) + 1);
  localparam logic [12:0] MODE     = mode_word(BURST_LEN, BURST_INTERLEAVE, CAS_LAT, WRITE_SINGLE);

  logic          t_load, t_expired, pending, take, pre_all, lmr_sel;
  logic [TW-1:0] t_val;
  sd_cmd_e       cmd;
  logic [ADDR_W-1:0] all_bank_addr;

  sdram_init_timer #(.W(TW), .RST_VAL(PWR_CYC - 1)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_expired)
  );

  sdram_init_fsm #(.T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD), .W(TW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .expired(t_expired), .ref_pending(pending),
    .ref_gnt(ref_gnt), .t_load(t_load), .t_val(t_val), .cmd(cmd),
    .pre_all(pre_all), .lmr_sel(lmr_sel), .done(init_done), .req(ref_req), .take(take)
  );

  sdram_refresh_pacer #(.INTERVAL(REFI_CYC), .MAX_OWED(MAX_OWED)) u_pacer (
    .clk(clk), .rst_n(rst_n), .en(init_done), .take(take), .pending(pending)
  );

  always_comb begin
    all_bank_addr     = '0;
    all_bank_addr[10] = 1'b1;
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_addr = lmr_sel ? ADDR_W'(MODE) : (pre_all ? all_bank_addr : '0);
  assign sd_ba   = '0;
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk
  import sdram_init_pkg::*;
#(
  parameter int BURST_LEN        = 4,
  parameter int BURST_INTERLEAVE = 0,
  parameter int CAS_LAT          = 3,
  parameter int WRITE_SINGLE     = 0,
  parameter int ADDR_W           = 13,
  parameter int BA_W             = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_gnt,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [ADDR_W-1:0] sd_addr,
  input logic [BA_W-1:0]   sd_ba,
  input logic              init_done,
  input logic              ref_req
);
  localparam logic [12:0] EXP_MODE = mode_word(BURST_LEN, BURST_INTERLEAVE, CAS_LAT, WRITE_SINGLE);
  logic [3:0] c;
  assign c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  a_r1_no_req_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !ref_req);
  a_r3_precharge_all: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0010) |-> sd_addr[10]);
  a_r5_mode_word: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0000) |-> (sd_addr == ADDR_W'(EXP_MODE) && sd_ba == '0 && !init_done));
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  a_r7_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt) |=> ref_req);
  a_r8_ref_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_gnt) |=> (c == 4'b0001 && !ref_req));
  a_r9_no_unrequested_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !(ref_req && ref_gnt)) |=> (c != 4'b0001));
endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .BURST_LEN(BURST_LEN), .BURST_INTERLEAVE(BURST_INTERLEAVE), .CAS_LAT(CAS_LAT),
  .WRITE_SINGLE(WRITE_SINGLE), .ADDR_W(ADDR_W), .BA_W(BA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba),
  .init_done(init_done), .ref_req(ref_req)
);

// File: tb/sdram_init_seq_tb_top.sv
module sdram_init_seq_tb_top;
  localparam int CLK_MHZ = 50, POWERUP_US = 2, REFRESH_NS = 600;
  localparam int T_RP = 3, T_RFC = 7, T_MRD = 2, MAX_OWED = 3;
  localparam int PWR  = CLK_MHZ * POWERUP_US;
  localparam int REFI = CLK_MHZ * REFRESH_NS / 1000;
  localparam int T_PRE = PWR, T_REF1 = PWR + T_RP, T_REF2 = T_REF1 + T_RFC;
  localparam int T_LMR = T_REF2 + T_RFC, T_DONE = T_LMR + T_MRD;
  localparam int NCYC = 1400;
  // R5 fields: BL 4 -> 010, sequential, CL 3, single-location writes
  localparam int EXP_MODE = 2 | (0 << 3) | (3 << 4) | (1 << 9);

  logic clk = 1'b0;
  logic rst_n, ref_gnt;
  logic cs_n, ras_n, cas_n, we_n, init_done, ref_req;
  logic [12:0] addr;
  logic [1:0]  ba;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sdram_init_seq #(
    .CLK_MHZ(CLK_MHZ), .POWERUP_US(POWERUP_US), .REFRESH_NS(REFRESH_NS),
    .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD), .BURST_LEN(4), .BURST_INTERLEAVE(0),
    .CAS_LAT(3), .WRITE_SINGLE(1), .MAX_OWED(MAX_OWED), .ADDR_W(13), .BA_W(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .sd_cs_n(cs_n), .sd_ras_n(ras_n),
    .sd_cas_n(cas_n), .sd_we_n(we_n), .sd_addr(addr), .sd_ba(ba),
    .init_done(init_done), .ref_req(ref_req)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int owed = 0, busy_until = 0, ref_at = -1;
    rst_n = 1'b0;
    ref_gnt = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "cmd in reset", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk("R1", "init_done in reset", init_done, 0);
    chk("R1", "ref_req in reset", ref_req, 0);
    rst_n = 1'b1;
    for (int n = 0; n < NCYC; n++) begin
      int    e_cmd, e_addr, e_req, g, tick, take;
      string tag, rtag;
      e_cmd = 4'b0111; e_addr = 0;
      if (n == T_PRE) begin e_cmd = 4'b0010; e_addr = 1 << 10; end
      else if (n == T_REF1 || n == T_REF2) e_cmd = 4'b0001;
      else if (n == T_LMR) begin e_cmd = 4'b0000; e_addr = EXP_MODE; end
      else if (n == ref_at) e_cmd = 4'b0001;
      e_req = (n >= T_DONE && owed > 0 && n >= busy_until) ? 1 : 0;

      if (n == 0)              tag = "R1";
      else if (n < T_PRE)      tag = "R2";
      else if (n < T_REF1)     tag = "R3";
      else if (n < T_LMR)      tag = "R4";
      else if (n == T_LMR)     tag = "R5";
      else if (n < T_DONE)     tag = "R6";
      else if (n >= 700 && n < 760) tag = "R10";
      else if (n == ref_at)    tag = "R8";
      else                     tag = "R9";
      rtag = (n >= 700 && n < 760) ? "R10" : "R7";

      chk(tag, $sformatf("cmd @%0d", n), {cs_n, ras_n, cas_n, we_n}, e_cmd);
      chk(tag, $sformatf("addr @%0d", n), addr, e_addr);
      chk(tag, $sformatf("ba @%0d", n), ba, 0);
      chk("R6", $sformatf("init_done @%0d", n), init_done, (n >= T_DONE) ? 1 : 0);
      chk(rtag, $sformatf("ref_req @%0d", n), ref_req, e_req);

      if (n < 400)       g = 1;
      else if (n < 700)  g = 0;
      else if (n < 1000) g = 1;
      else               g = (n % 5 == 0) ? 1 : 0;
      ref_gnt = g[0];

      tick = (n >= T_DONE && ((n - T_DONE + 1) % REFI) == 0) ? 1 : 0;
      take = e_req & g;
      if (take != 0) begin
        ref_at = n + 1;
        busy_until = n + 1 + T_RFC;
      end
      owed = owed + tick - take;
      if (owed > MAX_OWED) owed = MAX_OWED;
      @(negedge clk);
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule